// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Sequencer

This block sits between a simple request port and a single 4-bit-wide EDO DRAM device. A host offers a 24-bit word address, a direction bit and a nibble of write data on a valid/ready handshake. The sequencer splits the address into a row half and a column half and drives both on one multiplexed pin bus. It opens a row by lowering the row strobe, then runs one column strobe cycle per request. Read words come back on a one-cycle response pulse, in the order the reads were issued.

After an access the row is left open. A later request to the same row becomes another column cycle inside the same row-strobe-low period. A request to another row, a refresh request from the neighbouring refresh block, or a row that has been open nearly as long as the device allows all close the row with a precharge first.

Every analog limit is given in nanoseconds as a parameter. The clock count used for it is the ceiling of the limit divided by the clock period. Writes are always early writes: write-enable is already low when the column strobe falls. Reads rely on extended data-out. The column strobe rises early, and the read word is captured once the column and row access times are covered, before the next column strobe falls.

Top module: `edo_seq`

## Requirements
- R1: Out of reset, both strobes, write-enable and output-enable are high, the data bus is released, no response is pending and `req_ready` is 1.
- R2: When the row strobe falls, `dram_addr` carries the upper `ROW_BITS` bits of the request address (default 12, 13 selectable). When a column strobe falls, it carries the lower `24-ROW_BITS` bits. Both values are zero-extended to the pin width.
- R3: The first column strobe fall of a row comes at least ceil(tRCD/clk) clocks after the row strobe fall. The column strobe is only ever low while the row strobe is low.
- R4: A request to the open row is served as a further column cycle with no rise of the row strobe.
- R5: A request to a different row closes the open row. Every fall of the row strobe follows at least ceil(tRP/clk) clocks of row strobe high.
- R6: A write drives write-enable low and presents the write nibble with the bus enable set from the column strobe fall. Output-enable stays high. The bus enable is set only while the column strobe and write-enable are both low.
- R7: A read holds write-enable high and output-enable low from its column strobe fall until its word is captured. Write-enable and output-enable are never low together.
- R8: The read word is sampled after the column strobe has risen. Sampling happens once at least ceil(max(tAA,tCAC)/clk) clocks have passed since its column strobe fall and ceil(tRAC/clk) clocks since the row strobe fall, and before the next column strobe fall. It is returned on `rsp_valid`/`rsp_rdata` as output-enable rises.
- R9: Successive column strobe falls are at least ceil(tHPC/clk) clocks apart.
- R10: The row strobe is never low for more than ceil(tRASMAX/clk) clocks. A row nearing that limit is closed before it would be exceeded, even while same-row requests wait.
- R11: The row strobe stays low for at least max(ceil(tRAS/clk), ceil(tRC/clk) - ceil(tRP/clk)) clocks before it rises.
- R12: While `ref_req` is high, no request is accepted. An open row is closed as soon as R11 allows, and the row strobe then stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when valid is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Word address, row half in the upper bits |
| req_wdata | input | 4 | Write nibble |
| rsp_valid | output | 1 | One-cycle pulse with a read word |
| rsp_rdata | output | 4 | Read word |
| ref_req | input | 1 | Refresh block asks for the row to be closed and held closed |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write-enable, active low |
| dram_oe_n | output | 1 | Output-enable, active low |
| dram_addr | output | PIN_W | Multiplexed row/column pins |
| dram_dq_out | output | 4 | Data driven to the device |
| dram_dq_oe | output | 1 | Bus drive enable |
| dram_dq_in | input | 4 | Data returned by the device |

## Verification
The two decisions that can land in the same open-row cycle are serving a waiting same-row request as a page hit and closing the row because it is nearing its low-time limit. The bench provokes this with a shortened limit and a long stream of same-row reads. The row must close and reopen partway through, the row strobe must never stay low past the limit, and every read word must still match. The device model in the bench shows the wrong nibble whenever a read word would be sampled too early or after the next column fall, so the late-sample window is judged on the data itself.

// File: rtl/edo_pkg.sv
`timescale 1ns/1ps
package edo_pkg;

    localparam int ADDR_W = 24;
    localparam int DQ_W   = 4;

    // indices into the age counter bank
    localparam int AG_RAS = 0;   // clocks since row strobe fell
    localparam int AG_CAS = 1;   // clocks since column strobe fell
    localparam int AG_GAP = 2;   // clocks since a strobe rose (column or row)
    localparam int AG_N   = 3;

    typedef enum logic [2:0] {
        ST_IDLE,   // row closed, precharging or waiting
        ST_ACT,    // row strobe low, waiting for row-to-column delay
        ST_COL,    // column strobe low
        ST_CP,     // column strobe high, read word not yet captured
        ST_OPEN    // row open, column strobe high, ready for a hit
    } st_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DQ_W-1:0]   data;
    } req_t;

    function automatic int cdiv(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edo_age.sv
`timescale 1ns/1ps
module edo_age #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    output logic [W-1:0] age
);
    localparam logic [W-1:0] SAT = '1;

    // age is 1 in the first cycle after a restart and saturates at all-ones
    always_ff @(posedge clk) begin
        if (rst)
            age <= SAT;
        else if (restart)
            age <= W'(1);
        else if (age != SAT)
            age <= age + W'(1);
    end
endmodule

// File: rtl/edo_addr_split.sv
`timescale 1ns/1ps
module edo_addr_split import edo_pkg::*; #(
    parameter int ROW_BITS = 12,
    parameter int PIN_W    = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [PIN_W-1:0]  row,
    output logic [PIN_W-1:0]  col
);
    localparam int COL_BITS = ADDR_W - ROW_BITS;

    generate
        if (ROW_BITS == PIN_W) begin : g_row_wide
            assign row = addr[ADDR_W-1 -: ROW_BITS];
        end else begin : g_row_pad
            assign row = {{(PIN_W-ROW_BITS){1'b0}}, addr[ADDR_W-1 -: ROW_BITS]};
        end
        if (COL_BITS == PIN_W) begin : g_col_wide
            assign col = addr[COL_BITS-1:0];
        end else begin : g_col_pad
            assign col = {{(PIN_W-COL_BITS){1'b0}}, addr[COL_BITS-1:0]};
        end
    endgenerate
endmodule

// File: rtl/edo_seq.sv
`timescale 1ns/1ps
module edo_seq import edo_pkg::*; #(
    parameter int ROW_BITS    = 12,
    parameter int CLK_NS      = 10,
    parameter int TRCD_NS     = 14,
    parameter int TCAS_NS     = 10,
    parameter int TCAH_NS     = 10,
    parameter int TCP_NS      = 10,
    parameter int THPC_NS     = 25,
    parameter int TAA_NS      = 30,
    parameter int TCAC_NS     = 15,
    parameter int TRAC_NS     = 60,
    parameter int TRP_NS      = 40,
    parameter int TRC_NS      = 104,
    parameter int TRAS_NS     = 60,
    parameter int TRASMAX_NS  = 125000,
    localparam int PIN_W      = imax(ROW_BITS, ADDR_W - ROW_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DQ_W-1:0]   req_wdata,
    output logic              rsp_valid,
    output logic [DQ_W-1:0]   rsp_rdata,
    input  logic              ref_req,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [PIN_W-1:0]  dram_addr,
    output logic [DQ_W-1:0]   dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DQ_W-1:0]   dram_dq_in
);
    // clock counts derived from the nanosecond limits
    localparam int RCD_CK    = cdiv(TRCD_NS, CLK_NS);
    localparam int CASL_CK   = imax(cdiv(TCAS_NS, CLK_NS), cdiv(TCAH_NS, CLK_NS));
    localparam int CP_CK     = cdiv(TCP_NS, CLK_NS);
    localparam int HPC_CK    = cdiv(THPC_NS, CLK_NS);
    localparam int ACC_CK    = imax(cdiv(TAA_NS, CLK_NS), cdiv(TCAC_NS, CLK_NS));
    localparam int RAC_CK    = cdiv(TRAC_NS, CLK_NS);
    localparam int RP_CK     = cdiv(TRP_NS, CLK_NS);
    localparam int RASMIN_CK = imax(cdiv(TRAS_NS, CLK_NS), cdiv(TRC_NS, CLK_NS) - RP_CK);
    localparam int RASMAX_CK = TRASMAX_NS / CLK_NS;
    localparam int WORST_CK  = CASL_CK + imax(imax(CP_CK, HPC_CK), imax(ACC_CK, RAC_CK)) + 2;
    localparam int AGE_W     = $clog2(RASMAX_CK + WORST_CK + 2) + 1;

    typedef logic [AGE_W-1:0] age_t;
    localparam age_t RCD_A    = age_t'(RCD_CK);
    localparam age_t CASL_A   = age_t'(CASL_CK);
    localparam age_t CP_A     = age_t'(CP_CK);
    localparam age_t HPC_A    = age_t'(HPC_CK);
    localparam age_t ACC_A    = age_t'(ACC_CK);
    localparam age_t RAC_A    = age_t'(RAC_CK);
    localparam age_t RP_A     = age_t'(RP_CK);
    localparam age_t RASMIN_A = age_t'(RASMIN_CK);
    localparam age_t RASMAX_A = age_t'(RASMAX_CK);
    localparam age_t NEAR_A   = age_t'(RASMAX_CK - WORST_CK);

    st_e               st;
    req_t              req_q, req_in, src;
    logic [PIN_W-1:0]  sp_row, sp_col, open_row;
    logic [AG_N-1:0]   restart;
    age_t              age [AG_N];
    age_t              ras_age, cas_age, gap_age;
    logic              fire, near_limit, may_close, hit, cp_done;
    logic              go_act, go_col, go_cp, go_pre;

    assign req_in = '{wr: req_write, addr: req_addr, data: req_wdata};
    // new request while idle or open, latched one otherwise
    assign src = (st == ST_IDLE || st == ST_OPEN) ? req_in : req_q;

    edo_addr_split #(.ROW_BITS(ROW_BITS), .PIN_W(PIN_W)) u_split (
        .addr(src.addr), .row(sp_row), .col(sp_col)
    );

    generate
        for (genvar g = 0; g < AG_N; g++) begin : g_age
            edo_age #(.W(AGE_W)) u_age (
                .clk(clk), .rst(rst), .restart(restart[g]), .age(age[g])
            );
        end
    endgenerate

    assign ras_age = age[AG_RAS];
    assign cas_age = age[AG_CAS];
    assign gap_age = age[AG_GAP];

    assign hit        = (sp_row == open_row);
    assign near_limit = (ras_age >= NEAR_A);
    assign may_close  = (ras_age >= RASMIN_A);
    assign cp_done    = (gap_age >= CP_A) && (cas_age >= HPC_A) &&
                        (req_q.wr || ((cas_age >= ACC_A) && (ras_age >= RAC_A)));

    always_comb begin
        req_ready = 1'b0;
        if (st == ST_IDLE)
            req_ready = (gap_age >= RP_A) && !ref_req;
        else if (st == ST_OPEN)
            req_ready = !ref_req && !near_limit && hit;
    end

    assign fire   = req_valid && req_ready;
    assign go_act = (st == ST_IDLE) && fire;
    assign go_col = ((st == ST_ACT) && (ras_age >= RCD_A)) || ((st == ST_OPEN) && fire);
    assign go_cp  = (st == ST_COL) && (cas_age >= CASL_A);
    assign go_pre = (st == ST_OPEN) && may_close &&
                    (ref_req || near_limit || (req_valid && !hit));

    always_comb begin
        restart         = '0;
        restart[AG_RAS] = go_act;
        restart[AG_CAS] = go_col;
        restart[AG_GAP] = go_cp || go_pre;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            dram_ras_n  <= 1'b1;
            dram_cas_n  <= 1'b1;
            dram_we_n   <= 1'b1;
            dram_oe_n   <= 1'b1;
            dram_addr   <= '0;
            dram_dq_out <= '0;
            dram_dq_oe  <= 1'b0;
            rsp_valid   <= 1'b0;
            rsp_rdata   <= '0;
            req_q       <= '0;
            open_row    <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (fire)
                req_q <= req_in;
            if (go_act) begin
                st         <= ST_ACT;
                dram_ras_n <= 1'b0;
                dram_addr  <= sp_row;
                open_row   <= sp_row;
            end
            if (go_col) begin
                st          <= ST_COL;
                dram_cas_n  <= 1'b0;
                dram_addr   <= sp_col;
                dram_we_n   <= !src.wr;
                dram_oe_n   <= src.wr;
                dram_dq_oe  <= src.wr;
                dram_dq_out <= src.data;
            end
            if (go_cp) begin
                st         <= ST_CP;
                dram_cas_n <= 1'b1;
                dram_we_n  <= 1'b1;
                dram_dq_oe <= 1'b0;
            end
            if ((st == ST_CP) && cp_done) begin
                st        <= ST_OPEN;
                dram_oe_n <= 1'b1;
                if (!req_q.wr) begin
                    rsp_valid <= 1'b1;
                    rsp_rdata <= dram_dq_in;
                end
            end
            if (go_pre) begin
                st         <= ST_IDLE;
                dram_ras_n <= 1'b1;
            end
        end
    end

    // R7
    we_oe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!dram_we_n && !dram_oe_n));

    // R6
    drive_window_chk: assert property (@(posedge clk) disable iff (rst)
        dram_dq_oe |-> (!dram_cas_n && !dram_we_n));

    // R3
    strobe_order_chk: assert property (@(posedge clk) disable iff (rst)
        !dram_cas_n |-> !dram_ras_n);

    // R10
    ras_limit_chk: assert property (@(posedge clk) disable iff (rst)
        !dram_ras_n |-> (ras_age <= RASMAX_A));

    // R5
    precharge_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dram_ras_n) |-> ($past(gap_age) >= RP_A));

    // R9
    cas_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dram_cas_n) |-> ($past(cas_age) >= HPC_A));

    // R8
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $rose(dram_oe_n));

endmodule

// File: tb/edo_seq_bench.sv
`timescale 1ns/1ps
module edo_seq_bench;

    localparam int ROWB     = 12;
    localparam int COLB     = 24 - ROWB;
    localparam int PW       = 12;
    localparam int CK_RP    = 4;   // ceil(40/10)
    localparam int CK_RCD   = 2;   // ceil(14/10)
    localparam int CK_AA    = 3;   // ceil(max(30,15)/10)
    localparam int CK_RAC   = 6;   // ceil(60/10)
    localparam int CK_HPC   = 3;   // ceil(25/10)
    localparam int CK_RMIN  = 7;   // max(6, 11-4)
    localparam int CK_RMAX  = 60;  // 600 ns limit used here
    localparam logic [11:0] ROWBASE = 12'hA50;
    localparam logic [11:0] COLBASE = 12'h3C0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
    logic [23:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [3:0] rsp_rdata;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [PW-1:0] dram_addr;
    logic [3:0] dram_dq_out, dram_dq_in;

    always #5 clk = ~clk;

    edo_seq #(.ROW_BITS(ROWB), .TRASMAX_NS(600)) u_edo_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ref_req(ref_req),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int vec = 0;
    int miss = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vec++;
        if (!ok) begin
            miss++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- device model ----------------
    logic [3:0] mem_m [256];
    logic [3:0] exp_mem [256];
    logic [23:0] last_addr = '0;
    logic [3:0]  last_data = '0;
    logic pr_ras = 1'b1, pr_cas = 1'b1, first_col = 1'b0, rd_pending = 1'b0;
    logic [3:0] rd_word = '0;
    logic [PW-1:0] row_m = '0;
    int ras_age_m = 1000, cas_age_m = 1000, hi_len = 1000, ras_falls = 0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem_m[i] = '0;
            exp_mem[i] = '0;
        end
    end

    // word shown only inside the extended-data-out window
    assign dram_dq_in = (rd_pending && !dram_oe_n && cas_age_m >= CK_AA &&
                         ras_age_m >= CK_RAC) ? rd_word : ~rd_word;

    always @(negedge clk) begin
        if (!rst) begin
            if (!dram_we_n && !dram_oe_n)
                chk(0, "R7 we/oe both low", 0, 1);
            // column strobe
            if (pr_cas && !dram_cas_n) begin
                chk(!dram_ras_n, "R3 cas under ras", dram_ras_n, 0);
                chk(cas_age_m >= CK_HPC, "R9 cas fall spacing", cas_age_m, CK_HPC);
                if (first_col)
                    chk(ras_age_m >= CK_RCD, "R3 ras-to-cas", ras_age_m, CK_RCD);
                first_col = 1'b0;
                chk(dram_addr == PW'(last_addr[COLB-1:0]), "R2 column pins",
                    int'(dram_addr), int'(last_addr[COLB-1:0]));
                if (!dram_we_n) begin
                    chk(dram_dq_oe && dram_oe_n && dram_dq_out == last_data,
                        "R6 early write drive", int'(dram_dq_out), int'(last_data));
                    mem_m[{row_m[3:0], dram_addr[3:0]}] = dram_dq_out;
                    rd_pending = 1'b0;
                end else begin
                    chk(!dram_oe_n && !dram_dq_oe, "R7 read strobes", int'(dram_oe_n), 0);
                    rd_word = mem_m[{row_m[3:0], dram_addr[3:0]}];
                    rd_pending = 1'b1;
                end
                cas_age_m = 1;
            end else begin
                if (!pr_cas && dram_cas_n)
                    chk(!dram_dq_oe, "R6 bus released", int'(dram_dq_oe), 0);
                cas_age_m++;
            end
            // row strobe
            if (pr_ras && !dram_ras_n) begin
                chk(hi_len >= CK_RP, "R5 precharge", hi_len, CK_RP);
                chk(dram_addr == PW'(last_addr[23 -: ROWB]), "R2 row pins",
                    int'(dram_addr), int'(last_addr[23 -: ROWB]));
                row_m = dram_addr;
                ras_falls++;
                first_col = 1'b1;
                ras_age_m = 1;
            end else if (!pr_ras && dram_ras_n) begin
                chk(ras_age_m >= CK_RMIN, "R11 ras low min", ras_age_m, CK_RMIN);
                chk(ras_age_m <= CK_RMAX, "R10 ras low max", ras_age_m, CK_RMAX);
                hi_len = 1;
                rd_pending = 1'b0;
            end else if (!dram_ras_n) begin
                ras_age_m++;
            end else begin
                hi_len++;
            end
            pr_ras = dram_ras_n;
            pr_cas = dram_cas_n;
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic [23:0] mk(input int r, input int c);
        return {ROWBASE | 12'(r), COLBASE | 12'(c)};
    endfunction

    function automatic logic [3:0] pat(input int r, input int c, input bit inv);
        logic [3:0] v;
        v = 4'((r * 5 + c * 3 + 1) & 15);
        return inv ? ~v : v;
    endfunction

    task automatic send(input bit wr, input int r, input int c, input logic [3:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = mk(r, c);
        req_wdata = d;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        last_addr = req_addr;
        last_data = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wr_op(input int r, input int c, input logic [3:0] d);
        send(1'b1, r, c, d);
        exp_mem[{4'(r), 4'(c)}] = d;
        repeat (4) @(negedge clk);
    endtask

    task automatic rd_op(input int r, input int c, input string tag);
        bit got;
        send(1'b0, r, c, 4'h0);
        got = 1'b0;
        for (int k = 0; k < 200 && !got; k++) begin
            @(negedge clk);
            if (rsp_valid) got = 1'b1;
        end
        chk(got, {tag, " response"}, int'(got), 1);
        if (got)
            chk(rsp_rdata == exp_mem[{4'(r), 4'(c)}], tag,
                int'(rsp_rdata), int'(exp_mem[{4'(r), 4'(c)}]));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        vec++;
        miss++;
        $display("FAIL R8 watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
        $finish;
    end

    initial begin : main
        int f0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !dram_dq_oe && !rsp_valid,
            "R1 strobes idle in reset", {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(req_ready, "R1 ready after reset", int'(req_ready), 1);

        // sweep writes: row by row (page hits inside a row)
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 8; c++)
                wr_op(r, c, pat(r, c, 0));
        // sweep reads column-major: every access misses the open row
        for (int c = 0; c < 8; c++)
            for (int r = 0; r < 4; r++)
                rd_op(r, c, "R8 miss-order read");

        // R4 page hits on a freshly opened row
        rd_op(0, 0, "R8 read");
        rd_op(1, 0, "R8 read");
        f0 = ras_falls;
        rd_op(1, 1, "R4 hit read");
        rd_op(1, 2, "R4 hit read");
        chk(ras_falls == f0, "R4 no reopen on hit", ras_falls - f0, 0);

        // R5 row miss reopens once
        f0 = ras_falls;
        rd_op(2, 3, "R5 miss read");
        chk(ras_falls == f0 + 1, "R5 reopen on miss", ras_falls - f0, 1);

        // mixed reads and writes in one page
        rd_op(3, 0, "R8 read");
        wr_op(3, 1, pat(3, 1, 1));
        rd_op(3, 1, "R6 write then read same page");
        wr_op(3, 2, pat(3, 2, 1));
        rd_op(3, 2, "R6 write then read same page");

        // R12 refresh request closes the row and blocks acceptance
        wr_op(0, 4, pat(0, 4, 1));
        @(negedge clk);
        ref_req = 1'b1;
        repeat (12) @(negedge clk);
        #1;
        chk(dram_ras_n, "R12 row closed", int'(dram_ras_n), 1);
        chk(!req_ready, "R12 no accept", int'(req_ready), 0);
        @(negedge clk);
        ref_req = 1'b0;
        rd_op(0, 4, "R12 read after refresh window");

        // R10 long same-row stream: limit forces close while hits wait
        f0 = ras_falls;
        for (int k = 0; k < 24; k++)
            rd_op(2, k % 8, "R10 stream read");
        chk(ras_falls >= f0 + 2, "R10 row closed at limit", ras_falls - f0, 2);

        // overwrite pass with inverted pattern, reversed order
        for (int r = 3; r >= 0; r--)
            for (int c = 7; c >= 0; c--)
                wr_op(r, c, pat(r, c, 1));
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 8; c++)
                rd_op(r, c, "R8 inverted read");

        repeat (20) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
        $finish;
    end

endmodule